// File: doc/BRIEF.md
# Squashable Instruction Buffer with Register Credits

This block holds fetched instructions between the fetch stage and dispatch. Each entry carries a sequence number and the count of destination registers the instruction will need. Fetch appends entries at the tail, and dispatch takes them from the head in program order. Alongside the queue the block keeps a signed pool of free physical-register credits. Each accepted entry consumes its destination count from the pool. Registers released at retirement and the counts of squashed entries are returned to it.

When the back end redirects the machine, it presents a squash sequence number. The block then walks backwards from the youngest entry and removes one entry per cycle for as long as that entry is younger than the squash point. A busy flag is raised for the whole walk, and both enqueue and dequeue are frozen while it is up. The block also keeps three running statistics: accumulated occupancy, cycles spent full, and entries dispatched.

Top module: `squash_ibuf`

## Requirements
- R1: After reset the buffer is empty, `level` is 0, `credit` equals NUM_PREGS, `sq_busy` is low and all three statistics are 0.
- R2: An entry is accepted on a clock edge when `enq_valid` is high, the buffer is not full, `sq_busy` is low and `rename_blocked` is low. An accepted entry is appended behind all entries already held, and `level` rises by one.
- R3: When `level` equals DEPTH, `full` is high and `enq_valid` has no effect on the contents.
- R4: `deq_valid` is high when the buffer holds an entry and no squash walk is running. In that state `deq_seq` and `deq_ndst` show the oldest entry. A clock edge with `deq_valid` and `deq_ready` both high removes that entry and adds one to `dispatched`. With the buffer empty, `deq_ready` changes nothing.
- R5: Every accepted entry subtracts its `enq_ndst` from `credit`, which is a two's-complement value and may go below zero.
- R6: `rename_blocked` is high exactly when `credit` is zero or negative. It drops as soon as returned registers bring `credit` above zero.
- R7: A clock edge with `free_valid` high adds `free_cnt` to `credit`. The result is capped at NUM_PREGS.
- R8: A `sq_valid` pulse while idle sets `sq_busy` on the next edge and stores `sq_seq` as the threshold. On each busy cycle, if the youngest entry's sequence number is greater than the threshold (unsigned 16-bit compare), that entry is removed and its destination count is returned to `credit`. The first busy cycle that finds no such entry clears `sq_busy` at its closing edge.
- R9: While `sq_busy` is high, `deq_valid` is low and neither enqueue nor dequeue changes the buffer.
- R10: A `sq_valid` pulse during a walk lowers the threshold to the smaller of the stored value and `sq_seq`. If the pulse arrives in the cycle the walk would end, the walk continues with the new threshold.
- R11: On every clock edge, `occ_sum` grows by the `level` held before that edge. `full_cycles` grows by one on every edge where the buffer was full beforehand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Fetch offers an entry |
| enq_seq | input | SEQ_W | Sequence number of the offered entry |
| enq_ndst | input | NDST_W | Destination-register count of the offered entry |
| deq_ready | input | 1 | Dispatch takes the head entry |
| deq_valid | output | 1 | Head entry is available |
| deq_seq | output | SEQ_W | Sequence number at the head |
| deq_ndst | output | NDST_W | Destination count at the head |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash point: entries younger than this are removed |
| sq_busy | output | 1 | Squash walk in progress |
| free_valid | input | 1 | Registers returned by retirement |
| free_cnt | input | clog2(NUM_PREGS+1) | Number of registers returned |
| full | output | 1 | Buffer holds DEPTH entries |
| empty | output | 1 | Buffer holds no entries |
| level | output | clog2(DEPTH+1) | Current occupancy |
| credit | output | CW (signed) | Free physical-register credits |
| rename_blocked | output | 1 | Credits exhausted |
| occ_sum | output | STAT_W | Accumulated occupancy |
| full_cycles | output | STAT_W | Cycles spent full |
| dispatched | output | STAT_W | Entries dispatched |

## Verification
A corrupted tail pointer, or a wrong threshold compare, shows up as a wrong `level` on the edge after the squash walk ends. The same fault also leaves a wrong `credit`, because each removed entry returns its count. A wrong credit is visible on `credit` and `rename_blocked` one edge after the offending enqueue, free or pop, and it persists until saturation masks it. A broken head pointer or storage slot shows up on `deq_seq` as soon as the affected entry reaches the head. The statistics then drift from the running sum of `level` by the next edge.

// File: rtl/squash_ibuf_pkg.sv
package squash_ibuf_pkg;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_WALK = 1'b1
  } sq_state_e;

  function automatic int unsigned ring_inc(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  function automatic int unsigned ring_dec(input int unsigned p, input int unsigned depth);
    return (p == 0) ? depth - 1 : p - 1;
  endfunction

endpackage

// File: rtl/squash_ibuf_store.sv
module squash_ibuf_store #(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 16,
  parameter int NDST_W = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [SEQ_W-1:0]  push_seq,
  input  logic [NDST_W-1:0] push_ndst,
  input  logic              pop_head,
  input  logic              pop_tail,
  output logic [SEQ_W-1:0]  head_seq,
  output logic [NDST_W-1:0] head_ndst,
  output logic [SEQ_W-1:0]  tail_seq,
  output logic [NDST_W-1:0] tail_ndst,
  output logic [CNT_W-1:0]  count
);
  import squash_ibuf_pkg::*;

  logic [PTR_W-1:0] head_q, head_n;
  logic [PTR_W-1:0] wr_q, wr_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [PTR_W-1:0] youngest;

  logic [SEQ_W-1:0]  seq_flat  [DEPTH];
  logic [NDST_W-1:0] ndst_flat [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [SEQ_W-1:0]  seq_r;
    logic [NDST_W-1:0] ndst_r;
    logic              wr_en;
    assign wr_en = push && (wr_q == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (wr_en) begin
        seq_r  <= push_seq;
        ndst_r <= push_ndst;
      end
    end
    assign seq_flat[i]  = seq_r;
    assign ndst_flat[i] = ndst_r;
  end

  always_comb begin
    youngest = PTR_W'(ring_dec(int'(wr_q), DEPTH));
    head_n   = head_q;
    wr_n     = wr_q;
    cnt_n    = cnt_q;
    if (push) begin
      wr_n  = PTR_W'(ring_inc(int'(wr_q), DEPTH));
      cnt_n = cnt_n + 1'b1;
    end
    if (pop_head) begin
      head_n = PTR_W'(ring_inc(int'(head_q), DEPTH));
      cnt_n  = cnt_n - 1'b1;
    end
    if (pop_tail) begin
      wr_n  = youngest;
      cnt_n = cnt_n - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      wr_q   <= '0;
      cnt_q  <= '0;
    end else if (push || pop_head || pop_tail) begin
      head_q <= head_n;
      wr_q   <= wr_n;
      cnt_q  <= cnt_n;
    end
  end

  assign head_seq  = seq_flat[head_q];
  assign head_ndst = ndst_flat[head_q];
  assign tail_seq  = seq_flat[youngest];
  assign tail_ndst = ndst_flat[youngest];
  assign count     = cnt_q;

endmodule

// File: rtl/squash_ibuf_credit.sv
module squash_ibuf_credit #(
  parameter int NUM_PREGS = 32,
  parameter int NDST_W    = 2,
  parameter int FREE_W    = 6,
  parameter int CW        = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take_en,
  input  logic [NDST_W-1:0]    take_cnt,
  input  logic                 free_en,
  input  logic [FREE_W-1:0]    free_cnt,
  input  logic                 ret_en,
  input  logic [NDST_W-1:0]    ret_cnt,
  output logic signed [CW-1:0] credit,
  output logic                 blocked
);
  localparam logic signed [CW:0]   CAP_W = (CW+1)'(NUM_PREGS);
  localparam logic signed [CW-1:0] CAP   = CW'(NUM_PREGS);

  logic signed [CW-1:0] cred_q, cred_n;
  logic signed [CW:0]   sum;
  logic                 upd;

  always_comb begin
    sum = {cred_q[CW-1], cred_q};
    if (take_en) sum = sum - $signed({{(CW+1-NDST_W){1'b0}}, take_cnt});
    if (free_en) sum = sum + $signed({{(CW+1-FREE_W){1'b0}}, free_cnt});
    if (ret_en)  sum = sum + $signed({{(CW+1-NDST_W){1'b0}}, ret_cnt});
    cred_n = (sum > CAP_W) ? CAP : sum[CW-1:0];
    upd    = take_en || free_en || ret_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cred_q <= CAP;
    end else if (upd) begin
      cred_q <= cred_n;
    end
  end

  assign credit  = cred_q;
  assign blocked = cred_q[CW-1] || (cred_q == '0);

endmodule

// File: rtl/squash_ibuf_stats.sv
module squash_ibuf_stats #(
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count,
  input  logic              dispatch,
  output logic [STAT_W-1:0] occ_sum,
  output logic [STAT_W-1:0] full_cycles,
  output logic [STAT_W-1:0] dispatched
);
  logic [STAT_W-1:0] occ_q, full_q, disp_q;
  logic [STAT_W-1:0] occ_n, full_n, disp_n;
  logic              at_cap;

  always_comb begin
    at_cap = (count == CNT_W'(DEPTH));
    occ_n  = occ_q + STAT_W'(count);
    full_n = full_q + STAT_W'(at_cap);
    disp_n = disp_q + STAT_W'(dispatch);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q  <= '0;
      full_q <= '0;
      disp_q <= '0;
    end else begin
      occ_q <= occ_n;
      if (at_cap)   full_q <= full_n;
      if (dispatch) disp_q <= disp_n;
    end
  end

  assign occ_sum     = occ_q;
  assign full_cycles = full_q;
  assign dispatched  = disp_q;

endmodule

// File: rtl/squash_ibuf.sv
module squash_ibuf #(
  parameter int DEPTH     = 16,
  parameter int SEQ_W     = 16,
  parameter int NDST_W    = 2,
  parameter int NUM_PREGS = 32,
  parameter int STAT_W    = 32,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int FREE_W = $clog2(NUM_PREGS + 1),
  localparam int CW     = ((FREE_W > NDST_W) ? FREE_W : NDST_W) + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enq_valid,
  input  logic [SEQ_W-1:0]     enq_seq,
  input  logic [NDST_W-1:0]    enq_ndst,
  input  logic                 deq_ready,
  output logic                 deq_valid,
  output logic [SEQ_W-1:0]     deq_seq,
  output logic [NDST_W-1:0]    deq_ndst,
  input  logic                 sq_valid,
  input  logic [SEQ_W-1:0]     sq_seq,
  output logic                 sq_busy,
  input  logic                 free_valid,
  input  logic [FREE_W-1:0]    free_cnt,
  output logic                 full,
  output logic                 empty,
  output logic [CNT_W-1:0]     level,
  output logic signed [CW-1:0] credit,
  output logic                 rename_blocked,
  output logic [STAT_W-1:0]    occ_sum,
  output logic [STAT_W-1:0]    full_cycles,
  output logic [STAT_W-1:0]    dispatched
);
  import squash_ibuf_pkg::*;

  sq_state_e         st_q, st_n;
  logic [SEQ_W-1:0]  thr_q, thr_n;

  logic [SEQ_W-1:0]  tail_seq;
  logic [NDST_W-1:0] tail_ndst;
  logic [CNT_W-1:0]  count;
  logic              walking;
  logic              enq_fire, deq_fire, sq_pop;

  assign walking = (st_q == SQ_WALK);
  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);

  assign enq_fire  = enq_valid && !full && !walking && !rename_blocked;
  assign deq_valid = !empty && !walking;
  assign deq_fire  = deq_valid && deq_ready;
  assign sq_pop    = walking && !empty && (tail_seq > thr_q);

  always_comb begin
    st_n  = (sq_pop || sq_valid) ? SQ_WALK : SQ_IDLE;
    thr_n = thr_q;
    if (sq_valid) begin
      thr_n = (walking && (thr_q < sq_seq)) ? thr_q : sq_seq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      thr_q <= '0;
    end else begin
      st_q <= st_n;
      if (sq_valid) thr_q <= thr_n;
    end
  end

  squash_ibuf_store #(
    .DEPTH (DEPTH),
    .SEQ_W (SEQ_W),
    .NDST_W(NDST_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (enq_fire),
    .push_seq (enq_seq),
    .push_ndst(enq_ndst),
    .pop_head (deq_fire),
    .pop_tail (sq_pop),
    .head_seq (deq_seq),
    .head_ndst(deq_ndst),
    .tail_seq (tail_seq),
    .tail_ndst(tail_ndst),
    .count    (count)
  );

  squash_ibuf_credit #(
    .NUM_PREGS(NUM_PREGS),
    .NDST_W   (NDST_W),
    .FREE_W   (FREE_W),
    .CW       (CW)
  ) u_credit (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_en (enq_fire),
    .take_cnt(enq_ndst),
    .free_en (free_valid),
    .free_cnt(free_cnt),
    .ret_en  (sq_pop),
    .ret_cnt (tail_ndst),
    .credit  (credit),
    .blocked (rename_blocked)
  );

  squash_ibuf_stats #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .STAT_W(STAT_W)
  ) u_stats (
    .clk        (clk),
    .rst_n      (rst_n),
    .count      (count),
    .dispatch   (deq_fire),
    .occ_sum    (occ_sum),
    .full_cycles(full_cycles),
    .dispatched (dispatched)
  );

  assign sq_busy = walking;
  assign level   = count;

endmodule

// File: rtl/squash_ibuf_chk.sv
module squash_ibuf_chk #(
  parameter int DEPTH     = 16,
  parameter int NUM_PREGS = 32,
  parameter int CNT_W     = 5,
  parameter int CW        = 8,
  parameter int STAT_W    = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 deq_valid,
  input logic                 deq_ready,
  input logic                 sq_valid,
  input logic                 sq_busy,
  input logic                 full,
  input logic [CNT_W-1:0]     level,
  input logic signed [CW-1:0] credit,
  input logic                 rename_blocked,
  input logic [STAT_W-1:0]    full_cycles,
  input logic [STAT_W-1:0]    dispatched
);
  localparam logic signed [CW-1:0] CAP = CW'(NUM_PREGS);

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH);

  assert_credit_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    credit <= CAP);

  assert_dispatch_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && deq_ready) |=> (dispatched == $past(dispatched) + STAT_W'(1)));

  assert_blocked_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rename_blocked && !sq_busy && !(deq_valid && deq_ready)) |=> (level == $past(level)));

  assert_busy_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sq_busy |=> ((level <= $past(level)) && (dispatched == $past(dispatched))));

  assert_squash_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_valid && !sq_busy) |=> sq_busy);

  assert_full_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> (full_cycles == $past(full_cycles) + STAT_W'(1)));

endmodule

bind squash_ibuf squash_ibuf_chk #(
  .DEPTH    (DEPTH),
  .NUM_PREGS(NUM_PREGS),
  .CNT_W    (CNT_W),
  .CW       (CW),
  .STAT_W   (STAT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .deq_valid     (deq_valid),
  .deq_ready     (deq_ready),
  .sq_valid      (sq_valid),
  .sq_busy       (sq_busy),
  .full          (full),
  .level         (level),
  .credit        (credit),
  .rename_blocked(rename_blocked),
  .full_cycles   (full_cycles),
  .dispatched    (dispatched)
);

// File: tb/squash_ibuf_test.sv
`timescale 1ns/1ps
module squash_ibuf_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int SEQ_W      = 16;
  localparam int NDST_W     = 2;
  localparam int NUM_PREGS  = 6;
  localparam int STAT_W     = 32;
  localparam int CNT_W      = $clog2(DEPTH + 1);
  localparam int FREE_W     = $clog2(NUM_PREGS + 1);
  localparam int CW         = ((FREE_W > NDST_W) ? FREE_W : NDST_W) + 2;

  logic clk = 1'b0;
  logic rst_n;
  logic enq_valid, deq_ready, sq_valid, free_valid;
  logic [SEQ_W-1:0]  enq_seq, sq_seq, deq_seq;
  logic [NDST_W-1:0] enq_ndst, deq_ndst;
  logic [FREE_W-1:0] free_cnt;
  logic deq_valid, sq_busy, full, empty, rename_blocked;
  logic [CNT_W-1:0] level;
  logic signed [CW-1:0] credit;
  logic [STAT_W-1:0] occ_sum, full_cycles, dispatched;

  always #(CLK_PERIOD/2) clk = ~clk;

  squash_ibuf #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .NDST_W(NDST_W),
    .NUM_PREGS(NUM_PREGS), .STAT_W(STAT_W)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_seq(enq_seq), .enq_ndst(enq_ndst),
    .deq_ready(deq_ready), .deq_valid(deq_valid), .deq_seq(deq_seq), .deq_ndst(deq_ndst),
    .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_busy(sq_busy),
    .free_valid(free_valid), .free_cnt(free_cnt),
    .full(full), .empty(empty), .level(level), .credit(credit),
    .rename_blocked(rename_blocked),
    .occ_sum(occ_sum), .full_cycles(full_cycles), .dispatched(dispatched)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // reference state derived from the requirements
  int q_seq[$];
  int q_nd[$];
  int m_credit;
  bit m_busy;
  int m_thr;
  longint m_occ, m_full, m_disp;
  int next_seq;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2", "level", longint'(level), longint'(q_seq.size()));
    chk("R3", "full", longint'(full), longint'(q_seq.size() == DEPTH));
    chk("R4", "empty", longint'(empty), longint'(q_seq.size() == 0));
    chk("R9", "deq_valid", longint'(deq_valid), longint'(q_seq.size() > 0 && !m_busy));
    if (q_seq.size() > 0) begin
      chk("R4", "deq_seq", longint'(deq_seq), longint'(q_seq[0]));
      chk("R4", "deq_ndst", longint'(deq_ndst), longint'(q_nd[0]));
    end
    chk("R5", "credit", longint'(int'(credit)), longint'(m_credit));
    chk("R6", "rename_blocked", longint'(rename_blocked), longint'(m_credit <= 0));
    chk("R8", "sq_busy", longint'(sq_busy), longint'(m_busy));
    chk("R11", "occ_sum", longint'(occ_sum), m_occ);
    chk("R11", "full_cycles", longint'(full_cycles), m_full);
    chk("R4", "dispatched", longint'(dispatched), m_disp);
  endtask

  task automatic cyc(input bit ev, input int es, input int en, input bit dr,
                     input bit fv, input int fc, input bit sv, input int ss);
    bit ea, da, pop;
    int ret, c;
    enq_valid = ev; enq_seq = SEQ_W'(es); enq_ndst = NDST_W'(en);
    deq_ready = dr; free_valid = fv; free_cnt = FREE_W'(fc);
    sq_valid = sv; sq_seq = SEQ_W'(ss);
    ea  = ev && q_seq.size() < DEPTH && !m_busy && m_credit > 0;
    da  = dr && q_seq.size() > 0 && !m_busy;
    m_occ += q_seq.size();
    if (q_seq.size() == DEPTH) m_full++;
    ret = 0;
    pop = m_busy && q_seq.size() > 0 && q_seq[q_seq.size()-1] > m_thr;
    if (da) begin void'(q_seq.pop_front()); void'(q_nd.pop_front()); m_disp++; end
    if (pop) begin void'(q_seq.pop_back()); ret = q_nd.pop_back(); end
    if (ea) begin q_seq.push_back(es & 16'hFFFF); q_nd.push_back(en); next_seq = (next_seq + 1) & 16'hFFFF; end
    c = m_credit - (ea ? en : 0) + (fv ? fc : 0) + ret;
    if (c > NUM_PREGS) c = NUM_PREGS;
    m_credit = c;
    if (sv) m_thr = (m_busy && m_thr < (ss & 16'hFFFF)) ? m_thr : (ss & 16'hFFFF);
    m_busy = pop || sv;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0, 0); endtask

  task automatic settle_squash();
    for (int i = 0; i < 2*DEPTH + 4 && m_busy; i++) idle();
  endtask

  task automatic clear_all(); // squash everything and refill credits
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    settle_squash();
    cyc(0, 0, 0, 0, 1, NUM_PREGS, 0, 0);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        fails++;
        checks++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin : main
    int lfsr, s0, ss;
    rst_n = 1'b0;
    enq_valid = 0; enq_seq = '0; enq_ndst = '0; deq_ready = 0;
    sq_valid = 0; sq_seq = '0; free_valid = 0; free_cnt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_credit = NUM_PREGS; m_busy = 0; m_thr = 0;
    m_occ = 0; m_full = 0; m_disp = 0;
    next_seq = 16'h7FFD;

    // R1 reset state
    chk("R1", "level", longint'(level), 0);
    chk("R1", "empty", longint'(empty), 1);
    chk("R1", "credit", longint'(int'(credit)), NUM_PREGS);
    chk("R1", "sq_busy", longint'(sq_busy), 0);
    chk("R1", "occ_sum", longint'(occ_sum), 0);
    chk("R1", "dispatched", longint'(dispatched), 0);

    // R2/R3: fill to capacity then offer one more; R5 credit drops
    for (int i = 0; i < DEPTH; i++) cyc(1, next_seq, 1, 0, 0, 0, 0, 0);
    chk("R5", "credit after four single-dest entries", longint'(int'(credit)), NUM_PREGS - DEPTH);
    s0 = next_seq;
    cyc(1, s0, 1, 0, 0, 0, 0, 0);
    chk("R3", "level with enqueue while full", longint'(level), DEPTH);
    // R4 dequeue order and empty dequeue
    cyc(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R4", "head after one dispatch", longint'(deq_seq), 16'h7FFE);
    for (int i = 0; i < DEPTH + 1; i++) cyc(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R4", "dispatched after draining", longint'(dispatched), DEPTH);

    // R6/R5: exhaust credits to negative, then release
    cyc(1, next_seq, 3, 0, 0, 0, 0, 0);  // credit 2 -> -1
    chk("R5", "credit negative", longint'(int'(credit)), -1);
    chk("R6", "blocked at negative credit", longint'(rename_blocked), 1);
    cyc(1, next_seq, 1, 0, 0, 0, 0, 0);
    chk("R6", "enqueue refused while blocked", longint'(level), 1);
    cyc(0, 0, 0, 0, 1, 2, 0, 0);
    chk("R6", "released after free", longint'(rename_blocked), 0);
    // R7 saturation
    cyc(0, 0, 0, 0, 1, NUM_PREGS, 0, 0);
    chk("R7", "credit saturates", longint'(int'(credit)), NUM_PREGS);

    // R8 sweep: every fill level against every cut point, crossing 0x8000
    for (int n = 0; n <= DEPTH; n++) begin
      for (int k = 0; k <= n; k++) begin
        clear_all();
        s0 = next_seq;
        for (int i = 0; i < n; i++) cyc(1, next_seq, i % 3, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, (s0 + k - 1) & 16'hFFFF);
        chk("R8", "busy after squash", longint'(sq_busy), 1);
        // R9: enqueue and dequeue offered during the walk
        cyc(1, next_seq, 1, 1, 0, 0, 0, 0);
        settle_squash();
        chk("R8", "entries kept at cut", longint'(level), k);
      end
    end

    // R10: second, older squash during a walk
    clear_all();
    s0 = next_seq;
    for (int i = 0; i < DEPTH; i++) cyc(1, next_seq, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, s0 + 2);
    cyc(0, 0, 0, 0, 0, 0, 1, s0);
    settle_squash();
    chk("R10", "threshold lowered to older squash", longint'(level), 1);
    // R10: younger squash during a walk does not raise the threshold
    clear_all();
    s0 = next_seq;
    for (int i = 0; i < DEPTH; i++) cyc(1, next_seq, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, s0);
    cyc(0, 0, 0, 0, 0, 0, 1, s0 + 2);
    settle_squash();
    chk("R10", "threshold kept at older squash", longint'(level), 1);

    // mixed traffic with the reference model
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = ((lfsr >> 1) | ((((lfsr >> 0) ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 16'hFFFF;
      ss = (next_seq - 1 - ((lfsr >> 12) & 3)) & 16'hFFFF;
      cyc(lfsr[0], next_seq, (lfsr >> 1) & 3, lfsr[3],
          lfsr[4] & lfsr[5], (lfsr >> 6) & 3, ((lfsr >> 8) & 15) == 0, ss);
    end
    chk("R11", "occupancy total after traffic", longint'(occ_sum), m_occ);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule